// File: doc/BRIEF.md
# Input Device Autopoll Scheduler

This block polls the attached input devices at a programmable interval so that the host sees keystrokes and pointer motion without asking for them. While polling is switched on, a prescaler divides the system clock down to one tick per millisecond. An interval counter counts those ticks and, when the programmed number of milliseconds has passed, the block raises a one-cycle poll request toward the device bus model. The request carries a 16-bit device enable mask.

The device bus model answers each request with a response holding a byte count and up to `MAX_BYTES` data bytes. A count of zero means no device had anything to say, and nothing is sent. A non-zero count is turned into an unsolicited packet, streamed one byte per cycle into the response buffer. The packet starts with a fixed two-byte header and then carries the device bytes.

Three configuration writes control the block: switching polling on or off, setting the interval in milliseconds, and loading the device mask. The timer restarts from zero after every expiry, whether or not the poll returned data.

Top module: `autopoll_sched`

## Requirements
- R1: After reset, polling is off, the interval is 20 ms, `poll_mask` reads 0xFFFF, and `poll_req` and `pkt_valid` are low.
- R2: While polling is on, `poll_req` is a one-cycle pulse. The first pulse comes `rate*TICK_DIV` cycles after the enabling write takes effect, and later pulses follow at that same spacing.
- R3: A response with count N>0, accepted while a poll is outstanding, yields min(N,MAX_BYTES)+2 bytes on consecutive cycles, starting the cycle after acceptance. The bytes are 0x00, then 0x40, then data byte i taken from `rsp_data[8*i+7:8*i]` in ascending i. `pkt_last` is high on the final byte only.
- R4: A response with count zero produces no packet, and the next poll still follows one interval after the previous one.
- R5: An enable write with a non-zero value turns polling on and starts the interval from zero. A write with zero turns polling off, and no poll request follows. A write that does not change the on/off state has no effect on the timer.
- R6: A non-zero interval write takes effect at once and, while polling is on, restarts the interval from zero. An interval write of zero is ignored.
- R7: A mask write loads `{cfg_mask_hi, cfg_mask_lo}` (high byte first) and `poll_mask` shows it from the next cycle.
- R8: No poll request is issued while a poll is outstanding or its packet is being emitted. An interval that expires during that time is skipped, and the timer restarts.
- R9: `rsp_valid` is ignored when no poll is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en_we | input | 1 | Enable write strobe |
| cfg_en_val | input | 8 | Enable value, non-zero switches polling on |
| cfg_rate_we | input | 1 | Interval write strobe |
| cfg_rate_val | input | 8 | Interval in milliseconds, zero refused |
| cfg_mask_we | input | 1 | Mask write strobe |
| cfg_mask_hi | input | 8 | Mask high byte |
| cfg_mask_lo | input | 8 | Mask low byte |
| rsp_valid | input | 1 | Poll response valid |
| rsp_len | input | LEN_W | Response byte count |
| rsp_data | input | 8*MAX_BYTES | Response bytes, byte 0 in the low bits |
| poll_req | output | 1 | One-cycle poll request |
| poll_mask | output | 16 | Current device enable mask |
| pkt_valid | output | 1 | Packet byte valid |
| pkt_byte | output | 8 | Packet byte |
| pkt_last | output | 1 | Final byte of the packet |

## Verification
The assertions assume that each configuration strobe is a single-cycle pulse and that at most one of the enable or interval strobes is raised in a given cycle. They also assume the device model answers only after a request and never sends a response that holds zero bytes while marked as a packet. The stimulus drives every strobe for exactly one cycle and never overlaps enable and interval writes. The only out-of-turn response it sends is a deliberate one, issued while polling is idle, to exercise R9.

// File: rtl/autopoll_pkg.sv
package autopoll_pkg;
  localparam logic [7:0] PKT_TYPE_DEV  = 8'h00;
  localparam logic [7:0] PKT_FLAG_POLL = 8'h40;
  localparam logic [7:0] RATE_RESET    = 8'd20;
  localparam logic [15:0] MASK_RESET   = 16'hFFFF;

  typedef enum logic [1:0] {
    PF_IDLE = 2'd0,
    PF_WAIT = 2'd1,
    PF_EMIT = 2'd2
  } pf_state_e;
endpackage

// File: rtl/ap_interval_timer.sv
module ap_interval_timer #(
  parameter int TICK_DIV = 250000,
  parameter int RATE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate,
  output logic              expire
);
  localparam int PRE_W = $clog2(TICK_DIV + 1);
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [RATE_W-1:0] ms_q, ms_d;
  logic              tick;

  always_comb begin
    tick   = run && (pre_q == PRE_TOP);
    expire = tick && (ms_q == rate - RATE_W'(1)) && !restart;
    if (restart || !run)   pre_d = '0;
    else if (tick)         pre_d = '0;
    else                   pre_d = pre_q + PRE_W'(1);
    if (restart || !run)   ms_d = '0;
    else if (expire)       ms_d = '0;
    else if (tick)         ms_d = ms_q + RATE_W'(1);
    else                   ms_d = ms_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else begin
      pre_q <= pre_d;
      ms_q  <= ms_d;
    end
  end
endmodule

// File: rtl/ap_packet_former.sv
module ap_packet_former
  import autopoll_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   expire,
  input  logic                   rsp_valid,
  input  logic [LEN_W-1:0]       rsp_len,
  input  logic [8*MAX_BYTES-1:0] rsp_data,
  output logic                   poll_req,
  output logic                   pkt_valid,
  output logic [7:0]             pkt_byte,
  output logic                   pkt_last
);
  localparam int IDX_W = $clog2(MAX_BYTES + 2);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BYTES);

  pf_state_e              st_q, st_d;
  logic [IDX_W-1:0]       idx_q, idx_d, end_q, end_d;
  logic [8*MAX_BYTES-1:0] data_q;
  logic                   cap_en, req_d, req_q;
  logic [LEN_W-1:0]       len_c;
  logic [IDX_W-1:0]       sel;
  logic [8*MAX_BYTES-1:0] data_sh;

  always_comb begin
    len_c  = (rsp_len > LEN_MAX) ? LEN_MAX : rsp_len;
    st_d   = st_q;
    idx_d  = idx_q;
    end_d  = end_q;
    cap_en = 1'b0;
    req_d  = 1'b0;
    unique case (st_q)
      PF_IDLE: if (expire) begin
        st_d  = PF_WAIT;
        req_d = 1'b1;
      end
      PF_WAIT: if (rsp_valid) begin
        if (len_c == '0) st_d = PF_IDLE;
        else begin
          st_d   = PF_EMIT;
          cap_en = 1'b1;
          idx_d  = '0;
          end_d  = IDX_W'(len_c) + IDX_W'(1);
        end
      end
      PF_EMIT: begin
        if (idx_q == end_q) st_d = PF_IDLE;
        else                idx_d = idx_q + IDX_W'(1);
      end
      default: st_d = PF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PF_IDLE;
      idx_q <= '0;
      end_q <= '0;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      end_q <= end_d;
      req_q <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (cap_en) data_q <= rsp_data;
  end

  always_comb begin
    sel      = idx_q - IDX_W'(2);
    data_sh  = data_q >> {sel, 3'b000};
    poll_req = req_q;
    pkt_valid = (st_q == PF_EMIT);
    pkt_last  = pkt_valid && (idx_q == end_q);
    if (idx_q == IDX_W'(0))      pkt_byte = PKT_TYPE_DEV;
    else if (idx_q == IDX_W'(1)) pkt_byte = PKT_FLAG_POLL;
    else                         pkt_byte = data_sh[7:0];
  end
endmodule

// File: rtl/autopoll_sched.sv
module autopoll_sched
  import autopoll_pkg::*;
#(
  parameter int TICK_DIV  = 250000,
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_en_we,
  input  logic [7:0]             cfg_en_val,
  input  logic                   cfg_rate_we,
  input  logic [7:0]             cfg_rate_val,
  input  logic                   cfg_mask_we,
  input  logic [7:0]             cfg_mask_hi,
  input  logic [7:0]             cfg_mask_lo,
  input  logic                   rsp_valid,
  input  logic [LEN_W-1:0]       rsp_len,
  input  logic [8*MAX_BYTES-1:0] rsp_data,
  output logic                   poll_req,
  output logic [15:0]            poll_mask,
  output logic                   pkt_valid,
  output logic [7:0]             pkt_byte,
  output logic                   pkt_last
);
  logic        en_q, en_chg, rate_ok, restart, expire;
  logic [7:0]  rate_q;
  logic [15:0] mask_q;

  always_comb begin
    en_chg  = cfg_en_we && ((cfg_en_val != 8'h00) != en_q);
    rate_ok = cfg_rate_we && (cfg_rate_val != 8'h00);
    restart = en_chg || (rate_ok && en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      rate_q <= RATE_RESET;
      mask_q <= MASK_RESET;
    end else begin
      if (en_chg)      en_q   <= !en_q;
      if (rate_ok)     rate_q <= cfg_rate_val;
      if (cfg_mask_we) mask_q <= {cfg_mask_hi, cfg_mask_lo};
    end
  end

  assign poll_mask = mask_q;

  ap_interval_timer #(.TICK_DIV(TICK_DIV), .RATE_W(8)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en_q),
    .restart (restart),
    .rate    (rate_q),
    .expire  (expire)
  );

  ap_packet_former #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_former (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .rsp_valid (rsp_valid),
    .rsp_len   (rsp_len),
    .rsp_data  (rsp_data),
    .poll_req  (poll_req),
    .pkt_valid (pkt_valid),
    .pkt_byte  (pkt_byte),
    .pkt_last  (pkt_last)
  );
endmodule

// File: rtl/autopoll_sched_checker.sv
module autopoll_sched_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_en_we,
  input logic [7:0]  cfg_en_val,
  input logic        cfg_mask_we,
  input logic [7:0]  cfg_mask_hi,
  input logic [7:0]  cfg_mask_lo,
  input logic        poll_req,
  input logic [15:0] poll_mask,
  input logic        pkt_valid,
  input logic [7:0]  pkt_byte
);
  a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req |=> !poll_req);

  a_r3_type_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_valid) |-> pkt_byte == 8'h00);

  a_r3_flag_second: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_valid) |=> (pkt_valid && pkt_byte == 8'h40));

  a_r5_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en_we && cfg_en_val == 8'h00) |=> !poll_req);

  a_r7_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mask_we |=> poll_mask == $past({cfg_mask_hi, cfg_mask_lo}));

  a_r8_no_req_emit: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !poll_req);
endmodule

bind autopoll_sched autopoll_sched_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_en_we   (cfg_en_we),
  .cfg_en_val  (cfg_en_val),
  .cfg_mask_we (cfg_mask_we),
  .cfg_mask_hi (cfg_mask_hi),
  .cfg_mask_lo (cfg_mask_lo),
  .poll_req    (poll_req),
  .poll_mask   (poll_mask),
  .pkt_valid   (pkt_valid),
  .pkt_byte    (pkt_byte)
);

// File: tb/autopoll_sched_test.sv
module autopoll_sched_test;
  localparam int D     = 4;
  localparam int MAXB  = 8;
  localparam int LW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en_we = 0, cfg_rate_we = 0, cfg_mask_we = 0;
  logic [7:0] cfg_en_val = 0, cfg_rate_val = 0, cfg_mask_hi = 0, cfg_mask_lo = 0;
  logic rsp_valid = 0;
  logic [LW-1:0] rsp_len = 0;
  logic [8*MAXB-1:0] rsp_data = 0;
  logic poll_req, pkt_valid, pkt_last;
  logic [15:0] poll_mask;
  logic [7:0] pkt_byte;

  always #2 clk = ~clk;

  autopoll_sched #(.TICK_DIV(D), .MAX_BYTES(MAXB), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_en_we(cfg_en_we), .cfg_en_val(cfg_en_val),
    .cfg_rate_we(cfg_rate_we), .cfg_rate_val(cfg_rate_val),
    .cfg_mask_we(cfg_mask_we), .cfg_mask_hi(cfg_mask_hi), .cfg_mask_lo(cfg_mask_lo),
    .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_data(rsp_data),
    .poll_req(poll_req), .poll_mask(poll_mask),
    .pkt_valid(pkt_valid), .pkt_byte(pkt_byte), .pkt_last(pkt_last));

  int checks = 0, errors = 0, cyc = 0, req_seen = 0, pkt_seen = 0;
  string tag = "R1";

  // reference model state
  bit m_en; int m_rate; logic [15:0] m_mask; int m_cnt; int m_st; bit m_req;
  logic [7:0] q[$];

  // responder controls
  bit resp_on = 0; int resp_dly = 2; int resp_n = 3; int cd = -1; bit spur = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_en = 0; m_rate = 20; m_mask = 16'hFFFF; m_cnt = 0; m_st = 0; m_req = 0;
      q.delete();
    end else begin
      bit en_chg, rate_ok, restart, expire, nreq;
      en_chg  = cfg_en_we && ((cfg_en_val != 0) != m_en);
      rate_ok = cfg_rate_we && (cfg_rate_val != 0);
      restart = en_chg || (rate_ok && m_en);
      expire  = m_en && !restart && (m_cnt == m_rate * D - 1);
      nreq = 0;
      case (m_st)
        0: if (expire) begin m_st = 1; nreq = 1; end
        1: if (rsp_valid) begin
             int n;
             n = (rsp_len > MAXB) ? MAXB : int'(rsp_len);
             if (n == 0) m_st = 0;
             else begin
               q.push_back(8'h00); q.push_back(8'h40);
               for (int i = 0; i < n; i++) q.push_back(rsp_data[8*i +: 8]);
               m_st = 2;
             end
           end
        default: begin
          void'(q.pop_front());
          if (q.size() == 0) m_st = 0;
        end
      endcase
      if (restart || !m_en || expire) m_cnt = 0; else m_cnt++;
      if (en_chg) m_en = !m_en;
      if (rate_ok) m_rate = int'(cfg_rate_val);
      if (cfg_mask_we) m_mask = {cfg_mask_hi, cfg_mask_lo};
      m_req = nreq;
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(poll_req === m_req, tag, "poll_req", poll_req, m_req);
      chk(pkt_valid === (m_st == 2), tag, "pkt_valid", pkt_valid, m_st == 2);
      chk(poll_mask === m_mask, tag, "poll_mask", poll_mask, m_mask);
      if (m_st == 2) begin
        chk(pkt_byte === q[0], tag, "pkt_byte", pkt_byte, q[0]);
        chk(pkt_last === (q.size() == 1), tag, "pkt_last", pkt_last, q.size() == 1);
      end
      if (poll_req) req_seen++;
      if (pkt_valid && pkt_last) pkt_seen++;
    end
    rsp_valid <= 0;
    if (spur) begin
      spur = 0;
      rsp_valid <= 1; rsp_len <= 4; rsp_data <= 64'h1122334455667788;
    end else if (poll_req && resp_on) cd = resp_dly;
    else if (cd > 0) cd--;
    else if (cd == 0) begin
      cd = -1;
      rsp_valid <= 1;
      rsp_len <= LW'(resp_n);
      rsp_data <= {$urandom, $urandom};
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_en(logic [7:0] v);
    @(negedge clk); cfg_en_we = 1; cfg_en_val = v;
    @(negedge clk); cfg_en_we = 0;
  endtask

  task automatic wr_rate(logic [7:0] v);
    @(negedge clk); cfg_rate_we = 1; cfg_rate_val = v;
    @(negedge clk); cfg_rate_we = 0;
  endtask

  initial begin
    int r0, p0;
    wait_cyc(3);
    rst_n = 1;
    // R1: reset state
    @(negedge clk);
    chk(poll_mask === 16'hFFFF, "R1", "reset mask", poll_mask, 16'hFFFF);
    chk(!poll_req && !pkt_valid, "R1", "reset outputs idle", {poll_req, pkt_valid}, 0);
    wait_cyc(100);
    chk(req_seen == 0, "R1", "no poll while off", req_seen, 0);
    // R9: stray response while idle
    tag = "R9"; spur = 1; wait_cyc(20);
    chk(pkt_seen == 0, "R9", "stray response ignored", pkt_seen, 0);
    // R2, R3: polling with data
    tag = "R3"; resp_on = 1; resp_n = 3; resp_dly = 2;
    wr_en(8'h01);
    wait_cyc(90);
    chk(req_seen == 1, "R2", "first poll after 20 ms", req_seen, 1);
    wait_cyc(250);
    chk(pkt_seen >= 3, "R3", "packets emitted", pkt_seen, 3);
    // R3: oversize count clamps
    resp_n = 12; wait_cyc(200);
    // R4: empty responses
    tag = "R4"; resp_n = 0; p0 = pkt_seen; r0 = req_seen;
    wait_cyc(250);
    chk(pkt_seen == p0, "R4", "no packet for empty poll", pkt_seen, p0);
    chk(req_seen - r0 >= 3, "R4", "polls continue", req_seen - r0, 3);
    // R5: same-state enable write
    tag = "R5"; resp_n = 2; wait_cyc(37);
    wr_en(8'h7F); wait_cyc(200);
    // R6: rate change mid-period, zero refused
    tag = "R6"; wait_cyc(23);
    wr_rate(8'd5); wait_cyc(100);
    wr_rate(8'd0); wait_cyc(100);
    // R8: busy skip with short interval and long emission
    tag = "R8"; resp_n = 8; resp_dly = 6;
    wr_rate(8'd1); wait_cyc(200);
    resp_dly = 2; resp_n = 3;
    // R7: mask write
    tag = "R7";
    @(negedge clk); cfg_mask_we = 1; cfg_mask_hi = 8'hA5; cfg_mask_lo = 8'h3C;
    @(negedge clk); cfg_mask_we = 0;
    chk(poll_mask === 16'hA53C, "R7", "mask high byte first", poll_mask, 16'hA53C);
    wait_cyc(30);
    // R5: disable
    tag = "R5"; wr_en(8'h00); wait_cyc(40); r0 = req_seen;
    wait_cyc(300);
    chk(req_seen == r0, "R5", "no poll after disable", req_seen, r0);
    // R1: reset mid-run
    wr_en(8'h01); wait_cyc(50);
    tag = "R1";
    @(negedge clk); rst_n = 0; wait_cyc(2); rst_n = 1;
    @(negedge clk);
    chk(poll_mask === 16'hFFFF, "R1", "mask after reset", poll_mask, 16'hFFFF);
    r0 = req_seen; wait_cyc(200);
    chk(req_seen == r0, "R1", "off after reset", req_seen, r0);
    summary();
  end
endmodule